// File: doc/BRIEF.md
# Thermostat Alarm with Consecutive-Fault Qualification

This block turns a stream of signed temperature samples into one over-temperature alarm pin. Each sample that arrives with a valid pulse is compared with two signed limits: an upper trip limit and a lower release limit. The alarm changes state only after a programmable number of consecutive samples (1, 2, 4 or 6) beyond the limit being watched. Any valid sample that falls short of that limit breaks the run and starts the count again.

An 8-bit configuration byte selects the run length, the pin polarity, the thermostat behaviour and a shutdown hold. In comparator behaviour the pin stays active while the temperature is hot and releases after a run of cold samples. In interrupt behaviour each qualified event (hot, then cold, then hot again) raises the pin, and the pin stays raised until a register-read pulse acknowledges it. Evaluation runs on every valid sample whatever the read pulse is doing, except where a read coincides with a sample during an acknowledgement wait (see R8).

Control is a four-state machine. `ST_WATCH_HI` counts samples above the upper limit. `ST_WATCH_LO` counts samples below the lower limit. `ST_HELD_HI` and `ST_HELD_LO` wait for a read acknowledgement. The transitions are named as follows. *trip_hot* goes from WATCH_HI on the qualifying run, to HELD_HI in interrupt behaviour or to WATCH_LO in comparator behaviour. *trip_cold* goes from WATCH_LO on the qualifying run, to HELD_LO in interrupt behaviour or to WATCH_HI in comparator behaviour. *ack_hot* goes from HELD_HI to WATCH_LO on a read. *ack_cold* goes from HELD_LO to WATCH_HI on a read.

Top module: `thermo_alarm`

## Requirements
- R1: After reset the machine is in WATCH_HI with an empty run count. With the configuration byte at zero, the pin is then inactive, which is high.
- R2: Configuration byte fields are: bits [4:3] the run-length code, bit [2] the polarity (1 = active high), bit [1] the behaviour (0 = comparator, 1 = interrupt) and bit [0] shutdown (1 = hold). Bits [7:5] have no effect on the pin.
- R3: Run-length code 00 needs 1 consecutive qualifying sample, 01 needs 2, 10 needs 4 and 11 needs 6.
- R4: In WATCH_HI a sample qualifies only when it is strictly greater than the upper limit. In WATCH_LO it qualifies only when it is strictly less than the lower limit, with both compared as signed values. A valid sample that does not qualify clears the run count, and a sample equal to a limit does not qualify.
- R5: In comparator behaviour the pin becomes active after a qualifying run in WATCH_HI and stays active in WATCH_LO. It becomes inactive after a qualifying run of cold samples.
- R6: In interrupt behaviour the pin becomes active on trip_hot and stays active, with samples ignored, until a read (ack_hot). It then stays inactive until a qualifying cold run (trip_cold), stays active until a read (ack_cold), and then watches for hot samples again.
- R7: A read pulse in WATCH_HI or WATCH_LO changes neither the pin nor the run count.
- R8: When a read and a sample fall in the same cycle, the state that the machine holds before that edge decides the outcome. In a HELD state the read acknowledges and the sample is discarded. In a WATCH state the sample is counted and may trip, and the read has no effect.
- R9: While shutdown is set, samples and reads are ignored, and the state and run count are held. Counting resumes from the held count when shutdown clears.
- R10: The pin level is the active level when the alarm is active and the opposite level otherwise. A change of polarity shows on the pin without waiting for a clock edge.
- R11: The pin changes at the clock edge that captures the sample completing a qualifying run, or at the edge that captures an acknowledging read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle pulse marking a completed conversion |
| smp_temp | input | DATA_W | Signed temperature sample |
| lim_hot | input | DATA_W | Signed upper trip limit |
| lim_cold | input | DATA_W | Signed lower release limit |
| cfg_byte | input | 8 | Configuration byte |
| rd_pulse | input | 1 | One-cycle pulse for any register read |
| alarm_pin | output | 1 | Alarm output, polarity applied |

## Verification
A read pulse and a sample pulse can arrive in the same cycle. The bench provokes this in both kinds of state. In a HELD state it drives a cold sample together with the read, using a run length of one, and expects the pin inactive afterwards, because the sample was discarded. In WATCH_HI it drives the last hot sample of a run together with a read, and expects the pin active, because the trip happens and the read is ignored. Every case is judged at the falling edge after the shared rising edge.

// File: rtl/thermo_alarm_pkg.sv
package thermo_alarm_pkg;

    typedef enum logic [1:0] {
        ST_WATCH_HI = 2'd0,
        ST_HELD_HI  = 2'd1,
        ST_WATCH_LO = 2'd2,
        ST_HELD_LO  = 2'd3
    } thermo_state_e;

    typedef struct packed {
        logic       spare;
        logic [1:0] resol;
        logic [1:0] run_code;
        logic       pol_high;
        logic       intr_mode;
        logic       shutdown;
    } thermo_cfg_t;

    localparam int CNT_W = 3;

    function automatic logic [CNT_W-1:0] run_need(input logic [1:0] code);
        if (code == 2'd0) return CNT_W'(1);
        return CNT_W'({code, 1'b0});
    endfunction

endpackage

// File: rtl/thermo_cfg_decode.sv
module thermo_cfg_decode
    import thermo_alarm_pkg::*;
(
    input  logic [7:0]       cfg_byte,
    output logic [CNT_W-1:0] need,
    output logic             pol_high,
    output logic             intr_mode,
    output logic             shutdown
);
    thermo_cfg_t cfg_s;

    always_comb begin
        cfg_s     = thermo_cfg_t'(cfg_byte);
        need      = run_need(cfg_s.run_code);
        pol_high  = cfg_s.pol_high;
        intr_mode = cfg_s.intr_mode;
        shutdown  = cfg_s.shutdown;
    end
endmodule

// File: rtl/thermo_run_count.sv
module thermo_run_count
    import thermo_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_take,
    input  logic             smp_match,
    input  logic [CNT_W-1:0] need,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
        hit     = smp_take && smp_match && (cnt_inc >= {1'b0, need});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (smp_take) begin
            if (!smp_match || hit) cnt <= '0;
            else                   cnt <= cnt_inc[CNT_W-1:0];
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(5));

    // R4
    run_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_take && !smp_match) |=> (cnt == '0));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_take |=> $stable(cnt));
endmodule

// File: rtl/thermo_alarm_fsm.sv
module thermo_alarm_fsm
    import thermo_alarm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic          hit,
    input  logic          rd_pulse,
    input  logic          intr_mode,
    input  logic          shutdown,
    output thermo_state_e state,
    output logic          smp_take,
    output logic          watch_hot,
    output logic          active
);
    thermo_state_e nxt;
    logic          ack;

    assign ack = rd_pulse && !shutdown;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WATCH_HI: if (hit) nxt = intr_mode ? ST_HELD_HI : ST_WATCH_LO;
            ST_HELD_HI:  if (ack) nxt = ST_WATCH_LO;
            ST_WATCH_LO: if (hit) nxt = intr_mode ? ST_HELD_LO : ST_WATCH_HI;
            ST_HELD_LO:  if (ack) nxt = ST_WATCH_HI;
            default:     nxt = ST_WATCH_HI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WATCH_HI;
        else        state <= nxt;
    end

    always_comb begin
        smp_take  = 1'b0;
        watch_hot = 1'b0;
        active    = 1'b0;
        unique case (state)
            ST_WATCH_HI: begin
                smp_take  = smp_vld && !shutdown;
                watch_hot = 1'b1;
            end
            ST_HELD_HI:  active = 1'b1;
            ST_WATCH_LO: begin
                smp_take = smp_vld && !shutdown;
                active   = !intr_mode;
            end
            ST_HELD_LO:  active = 1'b1;
            default:     active = 1'b0;
        endcase
    end

    // R9
    sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> $stable(state));

    // R6
    ack_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HELD_HI) && rd_pulse && !shutdown) |=> (state == ST_WATCH_LO));

    // R7
    watch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WATCH_HI) && !hit) |=> (state == ST_WATCH_HI));

    // R6
    held_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HELD_LO) && !rd_pulse) |=> (state == ST_HELD_LO));
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
    import thermo_alarm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_temp,
    input  logic [DATA_W-1:0] lim_hot,
    input  logic [DATA_W-1:0] lim_cold,
    input  logic [7:0]        cfg_byte,
    input  logic              rd_pulse,
    output logic              alarm_pin
);
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] run_cnt;
    logic             pol_high, intr_mode, shutdown;
    logic             smp_take, watch_hot, active, hit, smp_match;
    logic             is_above, is_below;
    thermo_state_e    state;

    thermo_cfg_decode u_cfg (
        .cfg_byte (cfg_byte),
        .need     (need),
        .pol_high (pol_high),
        .intr_mode(intr_mode),
        .shutdown (shutdown)
    );

    always_comb begin
        is_above  = $signed(smp_temp) > $signed(lim_hot);
        is_below  = $signed(smp_temp) < $signed(lim_cold);
        smp_match = watch_hot ? is_above : is_below;
    end

    thermo_run_count u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_take (smp_take),
        .smp_match(smp_match),
        .need     (need),
        .cnt      (run_cnt),
        .hit      (hit)
    );

    thermo_alarm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .hit      (hit),
        .rd_pulse (rd_pulse),
        .intr_mode(intr_mode),
        .shutdown (shutdown),
        .state    (state),
        .smp_take (smp_take),
        .watch_hot(watch_hot),
        .active   (active)
    );

    assign alarm_pin = pol_high ? active : !active;

    // R11
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && $stable(intr_mode)) |-> $past(smp_vld));

    // R5
    cmp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!intr_mode && (state == ST_WATCH_LO) && !smp_vld && !shutdown) |=> active);
endmodule

// File: tb/test_thermo_alarm.sv
module test_thermo_alarm;
    localparam int DW     = 16;
    localparam int CLK_NS = 10;
    localparam int HOT    = 100;
    localparam int COLD   = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] smp_temp = '0;
    logic [DW-1:0] lim_hot = DW'(HOT);
    logic [DW-1:0] lim_cold = DW'(COLD);
    logic [7:0]    cfg_byte = '0;
    logic          rd_pulse = 1'b0;
    logic          alarm_pin;

    int checks = 0;
    int fails  = 0;
    logic cur_pol = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    thermo_alarm #(.DATA_W(DW)) i_thermo_alarm (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
        .lim_hot(lim_hot), .lim_cold(lim_cold), .cfg_byte(cfg_byte),
        .rd_pulse(rd_pulse), .alarm_pin(alarm_pin)
    );

    task automatic expect_act(input logic act, input string req);
        logic exp_pin;
        exp_pin = cur_pol ? act : !act;
        checks++;
        if (alarm_pin !== exp_pin) begin
            fails++;
            $display("FAIL %s: pin=%b expected=%b (t=%0t)", req, alarm_pin, exp_pin, $time);
        end
    endtask

    task automatic set_cfg(input logic [2:0] spare, input logic [1:0] code,
                           input logic pol, input logic intr, input logic sd);
        @(negedge clk);
        cfg_byte = {spare, code, pol, intr, sd};
        cur_pol  = pol;
    endtask

    task automatic step(input int temp, input logic v, input logic rd);
        @(negedge clk);
        smp_vld  = v;
        smp_temp = DW'(temp);
        rd_pulse = rd;
        @(negedge clk);
        smp_vld  = 1'b0;
        rd_pulse = 1'b0;
    endtask

    task automatic burst(input int temp, input int n);
        for (int k = 0; k < n; k++) step(temp, 1'b1, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int need;
        logic [2:0] spare;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, cfg zero -> pin high (inactive, active-low)
        checks++;
        if (alarm_pin !== 1'b1) begin
            fails++;
            $display("FAIL R1: pin=%b expected=1", alarm_pin);
        end

        for (int code = 0; code < 4; code++) begin
            for (int intr = 0; intr < 2; intr++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    need  = (code == 0) ? 1 : 2 * code;
                    spare = (code[0]) ? 3'b101 : 3'b010; // R2 spare bits vary
                    do_reset();
                    set_cfg(spare, code[1:0], pol[0], intr[0], 1'b0);
                    expect_act(1'b0, "R1");
                    // R3/R4: run of need-1, broken by in-range or equal sample
                    burst(HOT + 50, need - 1);
                    expect_act(1'b0, "R3");
                    step(HOT, 1'b1, 1'b0);
                    expect_act(1'b0, "R4");
                    burst(-5 + HOT + 6, need - 1);
                    step(50, 1'b1, 1'b0);
                    expect_act(1'b0, "R4");
                    // R7: read during watch does not break run
                    burst(HOT + 1, need - 1);
                    step(0, 1'b0, 1'b1);
                    step(HOT + 1, 1'b1, 1'b0);
                    expect_act(1'b1, "R3");
                    if (intr == 0) begin
                        // R5 comparator release
                        burst(COLD - 1, need - 1);
                        expect_act(1'b1, "R5");
                        step(COLD, 1'b1, 1'b0);
                        burst(-300, need - 1);
                        expect_act(1'b1, "R5");
                        step(-300, 1'b1, 1'b0);
                        expect_act(1'b0, "R5");
                    end else begin
                        // R6 interrupt sequence
                        burst(-300, need);
                        expect_act(1'b1, "R6");
                        step(0, 1'b0, 1'b1);
                        expect_act(1'b0, "R6");
                        burst(COLD - 1, need - 1);
                        expect_act(1'b0, "R6");
                        step(COLD - 1, 1'b1, 1'b0);
                        expect_act(1'b1, "R6");
                        burst(HOT + 9, need);
                        expect_act(1'b1, "R6");
                        step(0, 1'b0, 1'b1);
                        expect_act(1'b0, "R6");
                        burst(HOT + 9, need);
                        expect_act(1'b1, "R6");
                    end
                    // R10 polarity flip acts without a clock edge
                    @(negedge clk);
                    cfg_byte[2] = !pol[0];
                    #1;
                    cur_pol = !pol[0];
                    expect_act((intr == 0) ? 1'b0 : 1'b1, "R10");
                end
            end
        end

        // R9 shutdown, comparator, run length 2, active high
        do_reset();
        set_cfg(3'b000, 2'b01, 1'b1, 1'b0, 1'b0);
        step(HOT + 1, 1'b1, 1'b0);
        set_cfg(3'b000, 2'b01, 1'b1, 1'b0, 1'b1);
        burst(HOT + 1, 5);
        expect_act(1'b0, "R9");
        set_cfg(3'b000, 2'b01, 1'b1, 1'b0, 1'b0);
        step(HOT + 1, 1'b1, 1'b0);
        expect_act(1'b1, "R9");

        // R9 shutdown holds interrupt flag against reads
        do_reset();
        set_cfg(3'b000, 2'b00, 1'b1, 1'b1, 1'b0);
        step(HOT + 1, 1'b1, 1'b0);
        set_cfg(3'b000, 2'b00, 1'b1, 1'b1, 1'b1);
        step(0, 1'b0, 1'b1);
        expect_act(1'b1, "R9");
        set_cfg(3'b000, 2'b00, 1'b1, 1'b1, 1'b0);
        step(0, 1'b0, 1'b1);
        expect_act(1'b0, "R9");

        // R8 same-cycle read and sample
        do_reset();
        set_cfg(3'b000, 2'b00, 1'b1, 1'b1, 1'b0);
        step(HOT + 1, 1'b1, 1'b1);
        expect_act(1'b1, "R8");
        step(COLD - 1, 1'b1, 1'b1);
        expect_act(1'b0, "R8");
        step(COLD - 1, 1'b1, 1'b0);
        expect_act(1'b1, "R8");

        // R11 pin changes at the capturing edge
        do_reset();
        set_cfg(3'b000, 2'b00, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_temp = DW'(HOT + 2);
        #1;
        expect_act(1'b0, "R11");
        @(posedge clk);
        #1;
        smp_vld = 1'b0;
        expect_act(1'b1, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule